// File: doc/BRIEF.md
# Edge-kicked watchdog

This block supervises a software heartbeat. Software must flip a kick line, in either direction, often enough. The block synchronizes the line and counts timebase ticks between flips. If the count reaches the timeout limit before a flip arrives, an active-low status output drops and stays down. That output is meant to drive the manual-reset input of a separate reset generator, so that a stalled program ends up reset. The reset stretching itself is not part of this block.

The timer is held at zero while the system reset flag is active, and it starts counting on the first clock after the flag clears. The status output is also pulled low while the supply-good flag is low. It comes back at once when the supply recovers, unless a timeout is still pending. When the kick line is reported as floating, the watchdog is switched off. The limit is a parameter counted in timebase ticks. The default is 1600 ticks, which gives a nominal 1.6 s with a 1 ms tick.

Top module: `edge_kick_watchdog`

## Requirements
- R1: After the asynchronous reset, with `supply_ok_i` high, `wdo_n_o` is high (no timeout pending).
- R2: With no kick edge, `rst_active_i` low and `kick_float_i` low, `wdo_n_o` goes low on the clock edge that samples the TIMEOUT_TICKS-th asserted `tick_i`, counted from the first clock edge on which the timer runs.
- R3: While `rst_active_i` is high, the timer stays at zero and no timeout can occur. The first clock edge after it goes low already counts a tick.
- R4: A rising or a falling transition on `kick_i` clears the timer and any pending timeout. It takes effect on the third clock edge after the new level is set up before an edge (two synchronizer stages plus the edge compare). A kick pulse one clock wide is detected.
- R5: Once timed out, `wdo_n_o` stays low and the timer stays frozen until a kick edge, `mr_n_i` sampled low on one clock edge, or `kick_float_i` high. Releasing by `mr_n_i` leaves the timer at zero.
- R6: When a kick edge and a timeout fall on the same clock edge, the kick wins: no timeout is recorded and the timer restarts from zero.
- R7: `supply_ok_i` low forces `wdo_n_o` low with no clock delay. When `supply_ok_i` returns high, `wdo_n_o` returns high at once unless a timeout is pending.
- R8: While `kick_float_i` is high, the timer is held at zero, a pending timeout is cleared, and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, far faster than the shortest kick pulse |
| rst_ni | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Asynchronous heartbeat line toggled by software |
| rst_active_i | input | 1 | High while the system reset is asserted |
| mr_n_i | input | 1 | Manual reset level, active low; clears a pending timeout |
| supply_ok_i | input | 1 | High while the supply is above its threshold |
| kick_float_i | input | 1 | High when the kick line is undriven; disables the watchdog |
| tick_i | input | 1 | Single-cycle timebase strobe |
| wdo_n_o | output | 1 | Active-low watchdog status |

## Verification
The checker watches several rules on every clock: the timer is held at zero under reset, the float flag and a kick edge clear the timer, a timeout is recorded only from the last count value on a tick, a pending timeout stays set unless a release condition was present, and the output is high whenever the supply is good and nothing is pending. Other behaviours only show up in the bench's scenarios. These are the exact expiry cycle for several tick spacings, the three-clock kick latency in both directions, detection of a one-clock pulse, the tie between a kick and a timeout, and the output following the supply flag with no clock delay.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic {
    WD_ARMED   = 1'b0,
    WD_EXPIRED = 1'b1
  } wd_state_e;

endpackage

// File: rtl/wdg_kick_edge.sv
// Brings the asynchronous kick line into the clock domain and flags any change.
module wdg_kick_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= kick_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign edge_o = sync_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/wdg_tick_timer.sv
// Counts timebase ticks up to the limit; a clear always beats the expiry.
module wdg_tick_timer #(
  parameter int LIMIT = 1600,
  parameter int CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             step;

  assign step     = run_i & tick_i;
  assign expire_o = step & (cnt_q == LAST) & ~clear_i;
  assign cnt_en   = clear_i | step;

  always_comb begin
    if (clear_i || expire_o) cnt_d = '0;
    else                     cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/wdg_expiry.sv
// Holds the timed-out condition until a release event.
module wdg_expiry
  import wdg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic release_i,
  input  logic expire_i,
  output logic expired_o
);

  wd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (release_i)     state_d = WD_ARMED;
    else if (expire_i) state_d = WD_EXPIRED;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= WD_ARMED;
    else         state_q <= state_d;
  end

  assign expired_o = (state_q == WD_EXPIRED);

endmodule

// File: rtl/edge_kick_watchdog.sv
module edge_kick_watchdog #(
  parameter int TIMEOUT_TICKS = 1600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  input  logic rst_active_i,
  input  logic mr_n_i,
  input  logic supply_ok_i,
  input  logic kick_float_i,
  input  logic tick_i,
  output logic wdo_n_o
);

  localparam int CNT_W = (TIMEOUT_TICKS > 2) ? $clog2(TIMEOUT_TICKS) : 1;

  logic             kick_edge_w;
  logic             expire_w;
  logic             expired_w;
  logic             timer_clear;
  logic             expiry_release;
  logic [CNT_W-1:0] cnt_w;

  wdg_kick_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .kick_i (kick_i),
    .edge_o (kick_edge_w)
  );

  assign timer_clear    = kick_edge_w | rst_active_i | kick_float_i;
  assign expiry_release = kick_edge_w | ~mr_n_i | kick_float_i;

  wdg_tick_timer #(.LIMIT(TIMEOUT_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (timer_clear),
    .run_i    (~expired_w),
    .tick_i   (tick_i),
    .cnt_o    (cnt_w),
    .expire_o (expire_w)
  );

  wdg_expiry u_expiry (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .release_i (expiry_release),
    .expire_i  (expire_w),
    .expired_o (expired_w)
  );

  // Supply path is combinational so recovery needs no clock edge.
  assign wdo_n_o = supply_ok_i & ~expired_w;

endmodule

// File: rtl/edge_kick_watchdog_chk.sv
module edge_kick_watchdog_chk #(
  parameter int LIMIT = 1600,
  parameter int CNT_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rst_active_i,
  input logic             mr_n_i,
  input logic             supply_ok_i,
  input logic             kick_float_i,
  input logic             tick_i,
  input logic             wdo_n_o,
  input logic             kick_edge,
  input logic [CNT_W-1:0] cnt,
  input logic             expired
);

  AST_TIMER_HELD_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active_i |=> (cnt == '0)); // R3

  AST_EXPIRY_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expired) |-> ($past(cnt) == CNT_W'(LIMIT - 1) && $past(tick_i))); // R2

  AST_EXPIRY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(expired) && $past(mr_n_i) && !$past(kick_edge) && !$past(kick_float_i)) |-> expired); // R5

  AST_KICK_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_edge |=> (!expired && cnt == '0)); // R6

  AST_FLOAT_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_float_i |=> (!expired && cnt == '0)); // R8

  AST_SUPPLY_RECOVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (supply_ok_i && !expired) |-> wdo_n_o); // R7

endmodule

bind edge_kick_watchdog edge_kick_watchdog_chk #(
  .LIMIT (TIMEOUT_TICKS),
  .CNT_W (CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rst_active_i (rst_active_i),
  .mr_n_i       (mr_n_i),
  .supply_ok_i  (supply_ok_i),
  .kick_float_i (kick_float_i),
  .tick_i       (tick_i),
  .wdo_n_o      (wdo_n_o),
  .kick_edge    (kick_edge_w),
  .cnt          (cnt_w),
  .expired      (expired_w)
);

// File: tb/edge_kick_watchdog_tb_top.sv
`timescale 1ns/1ps
module edge_kick_watchdog_tb_top;

  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_ni, kick_i, rst_active_i, mr_n_i, supply_ok_i, kick_float_i, tick_i;
  logic wdo_n_o;
  int   vectors = 0;
  int   fails   = 0;

  always #2.5 clk = ~clk;

  edge_kick_watchdog #(.TIMEOUT_TICKS(T), .SYNC_STAGES(2)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .kick_i       (kick_i),
    .rst_active_i (rst_active_i),
    .mr_n_i       (mr_n_i),
    .supply_ok_i  (supply_ok_i),
    .kick_float_i (kick_float_i),
    .tick_i       (tick_i),
    .wdo_n_o      (wdo_n_o)
  );

  task automatic chk(input string req, input logic exp);
    vectors++;
    if (wdo_n_o !== exp) begin
      fails++;
      $display("FAIL %s: wdo_n_o=%b expected=%b at %0t", req, wdo_n_o, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Clears any pending timeout and parks the timer at zero; counting starts next edge.
  task automatic restart();
    kick_float_i = 1'b0;
    rst_active_i = 1'b1;
    mr_n_i       = 1'b0;
    step(2);
    rst_active_i = 1'b0;
    mr_n_i       = 1'b1;
  endtask

  // Runs from zero with a tick every p clocks, checking every cycle.
  task automatic sweep(input int p);
    int ticks = 0;
    restart();
    for (int c = 0; c < (T + 2) * p; c++) begin
      tick_i = ((c % p) == p - 1);
      @(posedge clk);
      if (tick_i) ticks++;
      @(negedge clk);
      chk("R2", (ticks < T));
    end
    tick_i = 1'b1;
  endtask

  // From a freshly cleared timer (P=1): high for T-1 edges, low on the T-th.
  task automatic expect_expiry(input string req);
    step(T - 1);
    chk(req, 1'b1);
    step(1);
    chk(req, 1'b0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; kick_i = 1'b0; rst_active_i = 1'b0; mr_n_i = 1'b1;
    supply_ok_i = 1'b1; kick_float_i = 1'b0; tick_i = 1'b0;
    step(3);
    chk("R1", 1'b1);
    rst_ni = 1'b1;
    step(1);
    chk("R1", 1'b1);

    // R2: exact expiry for several tick spacings
    for (int p = 1; p <= 3; p++) sweep(p);

    // R3: reset flag holds timer cleared
    restart();
    rst_active_i = 1'b1;
    step(3 * T);
    chk("R3", 1'b1);
    rst_active_i = 1'b0;
    expect_expiry("R3");

    // R5: timeout is sticky, manual reset releases it
    step(20);
    chk("R5", 1'b0);
    mr_n_i = 1'b0;
    step(1);
    chk("R5", 1'b1);
    mr_n_i = 1'b1;
    expect_expiry("R5");

    // R4: rising edge releases after three edges
    kick_i = 1'b1;
    step(2);
    chk("R4", 1'b0);
    step(1);
    chk("R4", 1'b1);
    expect_expiry("R4");
    // R4: falling edge
    kick_i = 1'b0;
    step(3);
    chk("R4", 1'b1);
    expect_expiry("R4");

    // R4: mid-count clear restarts the full interval
    restart();
    step(3);
    kick_i = 1'b1;
    step(3);
    chk("R4", 1'b1);
    expect_expiry("R4");

    // R4: one-clock pulse detected
    restart();
    step(2);
    kick_i = 1'b0;
    step(1);
    kick_i = 1'b1;
    step(3);
    chk("R4", 1'b1);
    expect_expiry("R4");

    // R6: kick edge on the timeout edge wins
    restart();
    step(5);
    kick_i = 1'b0;
    step(3);
    chk("R6", 1'b1);
    expect_expiry("R6");

    // R7: supply flag acts without clock delay
    restart();
    step(3);
    supply_ok_i = 1'b0;
    #1 chk("R7", 1'b0);
    supply_ok_i = 1'b1;
    #1 chk("R7", 1'b1);
    @(negedge clk);
    step(T - 4);
    chk("R7", 1'b0);
    supply_ok_i = 1'b0;
    #1 chk("R7", 1'b0);
    supply_ok_i = 1'b1;
    #1 chk("R7", 1'b0);
    @(negedge clk);

    // R8: float clears a timeout and disables the watchdog
    restart();
    step(T);
    chk("R8", 1'b0);
    kick_float_i = 1'b1;
    step(1);
    chk("R8", 1'b1);
    step(3 * T);
    chk("R8", 1'b1);
    kick_float_i = 1'b0;
    expect_expiry("R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule